// File: doc/BRIEF.md
# Gray-Code Exponent Subset-Sum Accumulator

This block keeps the running additive state of a subset-product pseudo-random function evaluated in a counter-like mode. All ring elements are held as discrete logarithms, so a product of key polynomials becomes a lane-wise sum of 8-bit exponents taken modulo 256. The block stores one base vector and a set of key vectors. Each vector holds 128 exponents, packed eight to a 64-bit word. Software or a loader fills them through a write port while the block is idle.

The input counter walks a Gray-code sequence that starts at zero. On each step request the block finds the one Gray bit that flips. It then adds that key vector to the state, or subtracts it, depending on the bit's old value. Eight lanes are handled per cycle, so one update takes 16 cycles. A restart command copies the base vector into the state and rewinds the counter. A dump command streams the state out in eight beats of 16 field elements. Each element is the generator 3 raised to the stored exponent, modulo 257. The downstream transform and rounding stages consume this stream.

Top module: `gray_subset_accum`

## Requirements
- R1: After reset, busy, done and outValid are low, grayCnt is zero, and every state exponent is zero.
- R2: A step advances the internal step count n by one. grayCnt then shows n XOR (n>>1). The flipped bit index is the number of trailing zeros of n, which is 63 when n wraps to zero.
- R3: When the flipped bit was 0, each state exponent e becomes (e + key[idx][e_pos]) mod 256, with the carry dropped.
- R4: When the flipped bit was 1, each state exponent becomes (e - key[idx][e_pos]) mod 256, with the borrow dropped.
- R5: After an accepted step or restart, busy is high for exactly 16 cycles, starting in the cycle after the request. done is then high for exactly one cycle, in the cycle after busy falls.
- R6: A restart copies the base vector into the state and clears the step count, so grayCnt reads zero.
- R7: A dump gives eight consecutive beats with outValid high and outIdx counting 0 to 7. Lane j, at bits [9j+8:9j], carries 3^e mod 257 for the state exponent at position 16*outIdx + j.
- R8: While busy is high, writes and restart, step and dump requests are ignored.
- R9: When the block is idle and requests coincide, restart takes precedence over step, and step over dump. A write accepted in the same cycle as a step request is used by that step.
- R10: A write with wrKey=1 stores wrData into word wrWord of key vector wrKeyIdx. With wrKey=0 it stores into word wrWord of the base vector. Bits [8l+7:8l] hold the exponent at position 8*wrWord + l.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Vector memory write strobe |
| wrKey | input | 1 | 1 selects a key vector, 0 the base vector |
| wrKeyIdx | input | 6 | Key vector number |
| wrWord | input | 4 | Word within the vector (8 exponents) |
| wrData | input | 64 | Eight packed 8-bit exponents |
| restartReq | input | 1 | Load base into state and rewind counter |
| stepReq | input | 1 | Advance Gray counter and update state |
| dumpReq | input | 1 | Stream the state out as field elements |
| busy | output | 1 | An operation is in progress |
| done | output | 1 | One-cycle pulse at end of a step or restart |
| grayCnt | output | 64 | Current Gray-code input value |
| outValid | output | 1 | Dump beat valid |
| outIdx | output | 3 | Dump beat number |
| outData | output | 144 | Sixteen 9-bit field elements |

## Verification
Two functions can meet in one cycle: a vector write and a command request. The bench raises a key write in the same idle cycle as a step whose flip selects that key. It then judges the following dump against a model that includes the new value. The bench also drives restart, step and dump together, and then step and dump together. It judges the outcome from grayCnt and from whether outValid ever rises. Finally, writes and requests are injected during a busy update. A later restart and dump must show the base vector unchanged and the counter advanced only once.

// File: rtl/accum_pkg.sv
package accum_pkg;
  localparam int EXP_W = 8;
  localparam int FE_W  = 9;
  localparam int MOD_Q = 257;
  localparam int GEN_G = 3;

  typedef struct packed {
    logic updEn;
    logic loadEn;
    logic dumpEn;
    logic sub;
  } accStrobe_t;

  // generator raised to an exponent, square-and-multiply over the exponent bits
  function automatic logic [FE_W-1:0] expToField(input logic [EXP_W-1:0] ex);
    int acc;
    int sq;
    acc = 1;
    sq  = GEN_G;
    for (int b = 0; b < EXP_W; b++) begin
      if (ex[b]) acc = (acc * sq) % MOD_Q;
      sq = (sq * sq) % MOD_Q;
    end
    return acc[FE_W-1:0];
  endfunction
endpackage

// File: rtl/accum_ctrl.sv
module accum_ctrl
  import accum_pkg::*;
#(
  parameter int NUM_KEYS   = 64,
  parameter int WORDS      = 16,
  parameter int DUMP_BEATS = 8,
  localparam int KIW = $clog2(NUM_KEYS),
  localparam int WIW = $clog2(WORDS)
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                restartReq,
  input  logic                stepReq,
  input  logic                dumpReq,
  output logic                busy,
  output logic                done,
  output logic [NUM_KEYS-1:0] grayCnt,
  output accStrobe_t          strb,
  output logic [KIW-1:0]      keyIdx,
  output logic [WIW-1:0]      wordIdx
);
  typedef enum logic [1:0] {M_IDLE, M_UPD, M_LOAD, M_DUMP} mode_t;

  mode_t               mode;
  logic [NUM_KEYS-1:0] stepCnt;
  logic [NUM_KEYS-1:0] nextCnt;
  logic [KIW-1:0]      flipIdx;
  logic                subQ;

  assign nextCnt = stepCnt + 1'b1;
  assign grayCnt = stepCnt ^ (stepCnt >> 1);

  // lowest set bit of the new count; a wrap to zero flips the top bit
  always_comb begin
    flipIdx = KIW'(NUM_KEYS - 1);
    for (int i = NUM_KEYS - 1; i >= 0; i--) begin
      if (nextCnt[i]) flipIdx = KIW'(i);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      mode    <= M_IDLE;
      stepCnt <= '0;
      wordIdx <= '0;
      keyIdx  <= '0;
      subQ    <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (mode)
        M_IDLE: begin
          wordIdx <= '0;
          if (restartReq) begin
            mode    <= M_LOAD;
            stepCnt <= '0;
          end else if (stepReq) begin
            mode    <= M_UPD;
            stepCnt <= nextCnt;
            keyIdx  <= flipIdx;
            subQ    <= grayCnt[flipIdx];
          end else if (dumpReq) begin
            mode <= M_DUMP;
          end
        end
        M_UPD, M_LOAD: begin
          wordIdx <= wordIdx + 1'b1;
          if (wordIdx == WIW'(WORDS - 1)) begin
            mode    <= M_IDLE;
            done    <= 1'b1;
            wordIdx <= '0;
          end
        end
        default: begin
          wordIdx <= wordIdx + 1'b1;
          if (wordIdx == WIW'(DUMP_BEATS - 1)) begin
            mode    <= M_IDLE;
            wordIdx <= '0;
          end
        end
      endcase
    end
  end

  assign busy        = (mode != M_IDLE);
  assign strb.updEn  = (mode == M_UPD);
  assign strb.loadEn = (mode == M_LOAD);
  assign strb.dumpEn = (mode == M_DUMP);
  assign strb.sub    = subQ;

  // R2: exactly one Gray bit changes when an update begins
  p_single_flip_r2: assert property (@(posedge clk) disable iff (!rstN)
    (strb.updEn && wordIdx == '0) |-> $countones(grayCnt ^ $past(grayCnt)) == 1);

  // R8: the counter holds while an operation is running
  p_cnt_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy)) |-> $stable(stepCnt));

  // R5: done is a single-cycle pulse
  p_done_pulse_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R5: done only follows a busy period
  p_done_after_busy_r5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));
endmodule

// File: rtl/accum_datapath.sv
module accum_datapath
  import accum_pkg::*;
#(
  parameter int NUM_EXP   = 128,
  parameter int NUM_KEYS  = 64,
  parameter int LANES     = 8,
  parameter int OUT_LANES = 16,
  localparam int EW    = EXP_W,
  localparam int WORDS = NUM_EXP / LANES,
  localparam int DW    = LANES * EW,
  localparam int BEATS = NUM_EXP / OUT_LANES,
  localparam int WPB   = OUT_LANES / LANES,
  localparam int KIW   = $clog2(NUM_KEYS),
  localparam int WIW   = $clog2(WORDS),
  localparam int BIW   = $clog2(BEATS)
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    busy,
  input  accStrobe_t              strb,
  input  logic [KIW-1:0]          keyIdx,
  input  logic [WIW-1:0]          wordIdx,
  input  logic                    wrEn,
  input  logic                    wrKey,
  input  logic [KIW-1:0]          wrKeyIdx,
  input  logic [WIW-1:0]          wrWord,
  input  logic [DW-1:0]           wrData,
  output logic                    outValid,
  output logic [BIW-1:0]          outIdx,
  output logic [OUT_LANES*FE_W-1:0] outData
);
  logic [DW-1:0] keyMem   [NUM_KEYS*WORDS];
  logic [DW-1:0] baseMem  [WORDS];
  logic [DW-1:0] stateMem [WORDS];

  logic [DW-1:0] curWord;
  logic [DW-1:0] keyWord;
  logic [DW-1:0] newWord;
  logic [DW-1:0] rdWord [WPB];
  logic [OUT_LANES*FE_W-1:0] fieldVec;

  // vector loading, idle only
  always_ff @(posedge clk) begin
    if (wrEn && !busy) begin
      if (wrKey) keyMem[{wrKeyIdx, wrWord}] <= wrData;
      else       baseMem[wrWord] <= wrData;
    end
  end

  assign curWord = stateMem[wordIdx];
  assign keyWord = keyMem[{keyIdx, wordIdx}];

  // lane-wise modulo-256 add or subtract, carries dropped at lane edges
  for (genvar l = 0; l < LANES; l++) begin : g_lane
    logic [EW-1:0] a;
    logic [EW-1:0] b;
    assign a = curWord[l*EW +: EW];
    assign b = keyWord[l*EW +: EW];
    assign newWord[l*EW +: EW] = strb.sub ? (a - b) : (a + b);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int w = 0; w < WORDS; w++) stateMem[w] <= '0;
    end else if (strb.updEn) begin
      stateMem[wordIdx] <= newWord;
    end else if (strb.loadEn) begin
      stateMem[wordIdx] <= baseMem[wordIdx];
    end
  end

  // dump path: WPB state words per beat through the exponent table
  for (genvar p = 0; p < WPB; p++) begin : g_rd
    assign rdWord[p] = stateMem[WIW'(int'(wordIdx) * WPB + p)];
  end

  for (genvar j = 0; j < OUT_LANES; j++) begin : g_fld
    logic [EW-1:0] ex;
    assign ex = rdWord[j / LANES][(j % LANES)*EW +: EW];
    assign fieldVec[j*FE_W +: FE_W] = expToField(ex);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outIdx   <= '0;
      outData  <= '0;
    end else if (strb.dumpEn) begin
      outValid <= 1'b1;
      outIdx   <= BIW'(wordIdx);
      outData  <= fieldVec;
    end else begin
      outValid <= 1'b0;
    end
  end

  // R7: dump beats arrive in ascending order
  p_out_seq_r7: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(outValid)) |-> outIdx == $past(outIdx) + 1'b1);

  // R8: the base vector is untouched while busy
  p_base_hold_r8: assert property (@(posedge clk) disable iff (!rstN)
    busy |=> baseMem[0] == $past(baseMem[0]));
endmodule

// File: rtl/gray_subset_accum.sv
module gray_subset_accum
  import accum_pkg::*;
#(
  parameter int NUM_EXP   = 128,
  parameter int NUM_KEYS  = 64,
  parameter int LANES     = 8,
  parameter int OUT_LANES = 16,
  localparam int WORDS = NUM_EXP / LANES,
  localparam int DW    = LANES * EXP_W,
  localparam int BEATS = NUM_EXP / OUT_LANES,
  localparam int KIW   = $clog2(NUM_KEYS),
  localparam int WIW   = $clog2(WORDS),
  localparam int BIW   = $clog2(BEATS)
) (
  input  logic                      clk,
  input  logic                      rstN,
  input  logic                      wrEn,
  input  logic                      wrKey,
  input  logic [KIW-1:0]            wrKeyIdx,
  input  logic [WIW-1:0]            wrWord,
  input  logic [DW-1:0]             wrData,
  input  logic                      restartReq,
  input  logic                      stepReq,
  input  logic                      dumpReq,
  output logic                      busy,
  output logic                      done,
  output logic [NUM_KEYS-1:0]       grayCnt,
  output logic                      outValid,
  output logic [BIW-1:0]            outIdx,
  output logic [OUT_LANES*FE_W-1:0] outData
);
  accStrobe_t     strb;
  logic [KIW-1:0] keyIdx;
  logic [WIW-1:0] wordIdx;

  accum_ctrl #(
    .NUM_KEYS(NUM_KEYS), .WORDS(WORDS), .DUMP_BEATS(BEATS)
  ) i_ctrl (
    .clk(clk), .rstN(rstN),
    .restartReq(restartReq), .stepReq(stepReq), .dumpReq(dumpReq),
    .busy(busy), .done(done), .grayCnt(grayCnt),
    .strb(strb), .keyIdx(keyIdx), .wordIdx(wordIdx)
  );

  accum_datapath #(
    .NUM_EXP(NUM_EXP), .NUM_KEYS(NUM_KEYS), .LANES(LANES), .OUT_LANES(OUT_LANES)
  ) i_dp (
    .clk(clk), .rstN(rstN), .busy(busy), .strb(strb),
    .keyIdx(keyIdx), .wordIdx(wordIdx),
    .wrEn(wrEn), .wrKey(wrKey), .wrKeyIdx(wrKeyIdx), .wrWord(wrWord), .wrData(wrData),
    .outValid(outValid), .outIdx(outIdx), .outData(outData)
  );
endmodule

// File: tb/test_gray_subset_accum.sv
module test_gray_subset_accum;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic wrEn = 1'b0, wrKey = 1'b0;
  logic [5:0] wrKeyIdx = '0;
  logic [3:0] wrWord = '0;
  logic [63:0] wrData = '0;
  logic restartReq = 1'b0, stepReq = 1'b0, dumpReq = 1'b0;
  logic busy, done, outValid;
  logic [63:0] grayCnt;
  logic [2:0] outIdx;
  logic [143:0] outData;

  int errors = 0;
  int checks = 0;
  int mdl [128];
  int ovK = -1, ovE = -1, ovV = 0;
  logic [63:0] prevGray = '0;

  always #2.5 clk = ~clk;

  gray_subset_accum i_gray_subset_accum (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrKey(wrKey), .wrKeyIdx(wrKeyIdx),
    .wrWord(wrWord), .wrData(wrData), .restartReq(restartReq), .stepReq(stepReq),
    .dumpReq(dumpReq), .busy(busy), .done(done), .grayCnt(grayCnt),
    .outValid(outValid), .outIdx(outIdx), .outData(outData)
  );

  // bit 64: 1 = step, 0 = restart; bits 63:0 expected Gray value afterwards
  localparam logic [64:0] VEC [12] = '{
    {1'b0, 64'd0},  {1'b1, 64'd1},  {1'b1, 64'd3},  {1'b1, 64'd2},
    {1'b1, 64'd6},  {1'b1, 64'd7},  {1'b1, 64'd5},  {1'b1, 64'd4},
    {1'b1, 64'd12}, {1'b1, 64'd13}, {1'b1, 64'd15}, {1'b1, 64'd14}
  };

  function automatic int keyF(int k, int e);
    if (k == ovK && e == ovE) return ovV;
    return (k * 29 + e * 13 + 7) % 256;
  endfunction

  function automatic int baseF(int e);
    return (e * 5 + 200) % 256;
  endfunction

  function automatic int pow3(int e);
    int p = 1;
    for (int i = 0; i < e; i++) p = (p * 3) % 257;
    return p;
  endfunction

  task automatic check(input bit ok, input string req, input string what, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic finishRun();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog: actual=expired expected=finished");
    finishRun();
  end

  task automatic writeWord(input bit isKey, input int k, input int w, input logic [63:0] d);
    @(negedge clk);
    wrEn = 1'b1; wrKey = isKey; wrKeyIdx = 6'(k); wrWord = 4'(w); wrData = d;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  function automatic logic [63:0] packWord(input bit isKey, input int k, input int w);
    logic [63:0] d;
    for (int l = 0; l < 8; l++)
      d[l*8 +: 8] = 8'(isKey ? keyF(k, w*8 + l) : baseF(w*8 + l));
    return d;
  endfunction

  // pulse requests, then measure busy length and done pulse (R5)
  task automatic runOp(input bit r, input bit s, input bit d, input string req);
    int cyc = 0;
    @(negedge clk);
    restartReq = r; stepReq = s; dumpReq = d;
    @(negedge clk);
    restartReq = 0; stepReq = 0; dumpReq = 0;
    while (busy && cyc < 100) begin
      check(outValid == 1'b0, req, "no dump beat during op", outValid, 0);
      cyc++;
      @(negedge clk);
    end
    check(cyc == 16, "R5", {req, " busy length"}, cyc, 16);
    check(done == 1'b1, "R5", "done after busy", done, 1);
    @(negedge clk);
    check(done == 1'b0, "R5", "done single cycle", done, 0);
  endtask

  task automatic applyModel(input logic [63:0] newGray);
    logic [63:0] diff = newGray ^ prevGray;
    int idx = 0;
    bit oldBit;
    for (int i = 0; i < 64; i++) if (diff[i]) idx = i;
    oldBit = prevGray[idx];
    for (int e = 0; e < 128; e++)
      mdl[e] = oldBit ? (mdl[e] - keyF(idx, e) + 256) % 256 : (mdl[e] + keyF(idx, e)) % 256;
    prevGray = newGray;
  endtask

  task automatic dumpCheck(input string req);
    @(negedge clk);
    dumpReq = 1'b1;
    @(negedge clk);
    dumpReq = 1'b0;
    for (int b = 0; b < 8; b++) begin
      int bad = 0;
      int firstAct = 0, firstExp = 0;
      @(negedge clk);
      check(outValid && outIdx == 3'(b), "R7", "beat valid and index", outIdx, b);
      for (int j = 0; j < 16; j++) begin
        int act = int'(outData[j*9 +: 9]);
        int expv = pow3(mdl[b*16 + j]);
        if (act != expv && bad == 0) begin firstAct = act; firstExp = expv; end
        if (act != expv) bad++;
      end
      check(bad == 0, req, $sformatf("beat %0d field lanes", b), firstAct, firstExp);
    end
    @(negedge clk);
    check(outValid == 1'b0, "R7", "stream ends after 8 beats", outValid, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(busy == 0 && done == 0 && outValid == 0, "R1", "idle flags", {busy, done, outValid}, 0);
    check(grayCnt == 64'd0, "R1", "gray after reset", grayCnt, 0);
    for (int e = 0; e < 128; e++) mdl[e] = 0;
    dumpCheck("R1");

    // load all vectors (R10)
    for (int k = 0; k < 64; k++)
      for (int w = 0; w < 16; w++) writeWord(1'b1, k, w, packWord(1'b1, k, w));
    for (int w = 0; w < 16; w++) writeWord(1'b0, 0, w, packWord(1'b0, 0, w));

    // table walk: restart then Gray steps (R2 R3 R4 R6 R10)
    for (int v = 0; v < 12; v++) begin
      if (VEC[v][64]) begin
        runOp(1'b0, 1'b1, 1'b0, "R2");
        applyModel(VEC[v][63:0]);
      end else begin
        runOp(1'b1, 1'b0, 1'b0, "R6");
        for (int e = 0; e < 128; e++) mdl[e] = baseF(e);
        prevGray = '0;
      end
      check(grayCnt == VEC[v][63:0], "R2", "gray value", grayCnt, VEC[v][63:0]);
      dumpCheck(VEC[v][64] ? "R3 R4 R10" : "R6");
    end

    // R8: writes and requests while busy are dropped; step 12 subtracts key 2 (R4)
    @(negedge clk);
    stepReq = 1'b1;
    @(negedge clk);
    stepReq = 1'b0;
    repeat (3) @(negedge clk);
    wrEn = 1'b1; wrKey = 1'b0; wrWord = 4'd0; wrData = '1;
    stepReq = 1'b1; restartReq = 1'b1; dumpReq = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; stepReq = 1'b0; restartReq = 1'b0; dumpReq = 1'b0;
    while (busy) @(negedge clk);
    repeat (2) @(negedge clk);
    check(busy == 1'b0, "R8", "no second op started", busy, 0);
    check(grayCnt == 64'd10, "R8", "single step while busy", grayCnt, 10);
    applyModel(64'd10);
    dumpCheck("R4 R8");
    runOp(1'b1, 1'b0, 1'b0, "R6");
    for (int e = 0; e < 128; e++) mdl[e] = baseF(e);
    prevGray = '0;
    dumpCheck("R8 base unchanged");

    // R9: restart wins over step and dump
    runOp(1'b1, 1'b1, 1'b1, "R9");
    check(grayCnt == 64'd0, "R9", "restart priority", grayCnt, 0);
    // R9: step wins over dump
    runOp(1'b0, 1'b1, 1'b1, "R9");
    check(grayCnt == 64'd1, "R9", "step over dump", grayCnt, 1);
    applyModel(64'd1);
    // R9: write in same cycle as step flipping bit 1 is used by that step
    ovK = 1; ovE = 27; ovV = 250;
    @(negedge clk);
    wrEn = 1'b1; wrKey = 1'b1; wrKeyIdx = 6'd1; wrWord = 4'd3; wrData = packWord(1'b1, 1, 3);
    stepReq = 1'b1;
    @(negedge clk);
    wrEn = 1'b0; stepReq = 1'b0;
    while (busy) @(negedge clk);
    @(negedge clk);
    check(grayCnt == 64'd3, "R9", "gray after write+step", grayCnt, 3);
    applyModel(64'd3);
    dumpCheck("R9 R3");

    finishRun();
  end
endmodule